// File: doc/BRIEF.md
# Operator Console Deposit/Examine Sequencer

This block is the operator console controller for a small 12-bit minicomputer core. It reads a switch word and three momentary keys (set address, deposit, examine) from a front panel. It keeps the console program counter. On a deposit or examine key it runs a short sequence against a simple memory request interface. Each such access waits for the memory to acknowledge, then advances the program counter by one. The program counter, the last examined word and the address being accessed are driven back to the panel lamps.

The panel wiring presents every switch and lamp vector with its bits in reverse order. The block undoes that reversal on the way in and applies it again on the way out, so the memory side always uses natural bit order. The three bank-field switches are not interpreted. They go straight through to their lamps. A build parameter moves the deposit action from the press of its key to the release of its key.

Top module: `console_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle, `mem_valid` is 0, and the program counter, data and address lamps all read 0.
- R2: When the set-address key goes from 0 to 1 while the sequencer is idle, the program counter equals the switch word after the next clock edge, and no memory request is made.
- R3: A deposit action makes exactly one write request (`mem_write`=1) at the current program counter, with the switch word as write data. Address, data and direction hold steady until `mem_ack`. The clock edge that samples `mem_ack` sets the program counter to the access address plus one.
- R4: An examine action makes exactly one read request (`mem_write`=0) at the current program counter. The edge that samples `mem_ack` loads `mem_rdata` into the data lamps and sets the program counter to the access address plus one. The data lamps change at no other time.
- R5: Each key acts at most once per press. Holding a key down never repeats the action; the key must go back to 0 and then to 1 again.
- R6: A key edge that occurs while a memory access is outstanding is ignored and is not remembered. The sequencer returns to idle in the cycle after the acknowledge.
- R7: When several key edges reach an idle sequencer in the same cycle, only one acts. The priority is set-address first, then deposit, then examine; the other edges are dropped.
- R8: The program counter wraps from octal 7777 to 0000 when it advances.
- R9: Bit order: on `sw_word_pnl`, `sw_field_pnl` and every `disp_*_pnl` output, index 0 carries the most significant bit of the value. `mem_addr`, `mem_wdata` and `mem_rdata` use natural order, with index 0 as the least significant bit.
- R10: While `mem_valid` is 1 the address lamps show the access address. Afterwards they keep showing the last accessed address.
- R11: With `DEP_ON_RELEASE`=1, deposit acts on the 1-to-0 transition of its key, and pressing the key alone makes no request.
- R12: The field lamps show the field switches unchanged, bit for bit, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_word_pnl | input | 12 | Switch word, panel (reversed) bit order |
| sw_field_pnl | input | 3 | Bank-field switches, panel bit order |
| key_load | input | 1 | Set-address key, level |
| key_dep | input | 1 | Deposit key, level |
| key_exam | input | 1 | Examine key, level |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | 12 | Read data, valid with `mem_ack` |
| mem_valid | output | 1 | Memory request pending |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Request address |
| mem_wdata | output | 12 | Write data |
| disp_pc_pnl | output | 12 | Program counter lamps, panel bit order |
| disp_data_pnl | output | 12 | Memory data lamps, panel bit order |
| disp_addr_pnl | output | 12 | Memory address lamps, panel bit order |
| disp_field_pnl | output | 3 | Field lamps, panel bit order |

## Verification
Two key actions can reach the sequencer in the same cycle in two ways. One is two keys rising on the same clock edge while it is idle. The other is a key edge arriving while a memory access is still waiting for its acknowledge. The bench raises set-address together with deposit, and deposit together with examine. It also pulses examine in the middle of a slow deposit. The scoreboard must see exactly the requests that the priority and busy rules allow, and no others. The lamp values are then compared with the program counter and data that those surviving actions alone produce.

// File: rtl/console_pkg.sv
package console_pkg;

    localparam int KEYS     = 3;
    localparam int KEY_LOAD = 0;
    localparam int KEY_DEP  = 1;
    localparam int KEY_EXAM = 2;

    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_ACCESS = 1'b1
    } seq_state_t;

endpackage

// File: rtl/panel_bitrev.sv
module panel_bitrev #(
    parameter int W = 12
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/key_edge.sv
module key_edge #(
    parameter int          N        = 3,
    parameter logic [N-1:0] REL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] keys,
    output logic [N-1:0] fire
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = keys;
    end

    for (genvar i = 0; i < N; i++) begin : g_key
        if (REL_MASK[i]) begin : g_rel
            assign fire[i] = !keys[i] && prev_q[i];
        end else begin : g_press
            assign fire[i] = keys[i] && !prev_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/seq_core.sv
module seq_core
    import console_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_load,
    input  logic         go_dep,
    input  logic         go_exam,
    input  logic [W-1:0] sw_word,
    input  logic         mem_ack,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_valid,
    output logic         mem_write,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic [W-1:0] pc,
    output logic [W-1:0] data,
    output logic [W-1:0] addr
);

    typedef struct packed {
        seq_state_t   st;
        logic         wr;
        logic [W-1:0] pc;
        logic [W-1:0] data;
        logic [W-1:0] addr;
        logic [W-1:0] wdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (go_load) begin
                    r_d.pc = sw_word;
                end else if (go_dep) begin
                    r_d.addr  = r_q.pc;
                    r_d.wdata = sw_word;
                    r_d.wr    = 1'b1;
                    r_d.st    = SEQ_ACCESS;
                end else if (go_exam) begin
                    r_d.addr = r_q.pc;
                    r_d.wr   = 1'b0;
                    r_d.st   = SEQ_ACCESS;
                end
            end
            SEQ_ACCESS: begin
                if (mem_ack) begin
                    if (!r_q.wr) begin
                        r_d.data = mem_rdata;
                    end
                    r_d.pc = r_q.addr + W'(1);
                    r_d.st = SEQ_IDLE;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: SEQ_IDLE, wr: 1'b0, pc: '0, data: '0, addr: '0, wdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_valid = (r_q.st == SEQ_ACCESS);
    assign mem_write = r_q.wr;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign pc        = r_q.pc;
    assign data      = r_q.data;
    assign addr      = r_q.addr;

endmodule

// File: rtl/console_seq.sv
module console_seq
    import console_pkg::*;
#(
    parameter int WORD_W         = 12,
    parameter int FIELD_W        = 3,
    parameter bit DEP_ON_RELEASE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] sw_word_pnl,
    input  logic [FIELD_W-1:0] sw_field_pnl,
    input  logic              key_load,
    input  logic              key_dep,
    input  logic              key_exam,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] disp_pc_pnl,
    output logic [WORD_W-1:0] disp_data_pnl,
    output logic [WORD_W-1:0] disp_addr_pnl,
    output logic [FIELD_W-1:0] disp_field_pnl
);

    localparam logic [KEYS-1:0] REL_MASK =
        DEP_ON_RELEASE ? (KEYS'(1) << KEY_DEP) : '0;

    logic [KEYS-1:0]    keys, fire;
    logic [WORD_W-1:0]  sw_word, pc, data, addr;
    logic [FIELD_W-1:0] field;

    assign keys[KEY_LOAD] = key_load;
    assign keys[KEY_DEP]  = key_dep;
    assign keys[KEY_EXAM] = key_exam;

    panel_bitrev #(.W(WORD_W))  u_rev_sw    (.din(sw_word_pnl),  .dout(sw_word));
    panel_bitrev #(.W(FIELD_W)) u_rev_fin   (.din(sw_field_pnl), .dout(field));
    panel_bitrev #(.W(FIELD_W)) u_rev_fout  (.din(field),        .dout(disp_field_pnl));
    panel_bitrev #(.W(WORD_W))  u_rev_pc    (.din(pc),           .dout(disp_pc_pnl));
    panel_bitrev #(.W(WORD_W))  u_rev_data  (.din(data),         .dout(disp_data_pnl));
    panel_bitrev #(.W(WORD_W))  u_rev_addr  (.din(addr),         .dout(disp_addr_pnl));

    key_edge #(.N(KEYS), .REL_MASK(REL_MASK)) u_keys (
        .clk  (clk),
        .rst  (rst),
        .keys (keys),
        .fire (fire)
    );

    seq_core #(.W(WORD_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .go_load   (fire[KEY_LOAD]),
        .go_dep    (fire[KEY_DEP]),
        .go_exam   (fire[KEY_EXAM]),
        .sw_word   (sw_word),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc        (pc),
        .data      (data),
        .addr      (addr)
    );

endmodule

// File: rtl/console_seq_chk.sv
module console_seq_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              key_load,
    input logic [WORD_W-1:0] sw_word_pnl,
    input logic              mem_valid,
    input logic              mem_ack,
    input logic              mem_write,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] mem_rdata,
    input logic [WORD_W-1:0] disp_pc_pnl,
    input logic [WORD_W-1:0] disp_data_pnl,
    input logic [WORD_W-1:0] disp_addr_pnl
);

    function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
        return r;
    endfunction

    a_r2_load_sets_pc: assert property (@(posedge clk) disable iff (rst)
        $rose(key_load) && !mem_valid |=> disp_pc_pnl == $past(sw_word_pnl));

    a_r3_request_held: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr)
            && $stable(mem_wdata) && $stable(mem_write));

    a_r8_pc_advances: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ack |=> flip(disp_pc_pnl) == $past(mem_addr) + WORD_W'(1));

    a_r4_exam_loads_data: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ack && !mem_write |=> flip(disp_data_pnl) == $past(mem_rdata));

    a_r4_data_quiet: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && mem_ack && !mem_write) |=> $stable(disp_data_pnl));

    a_r6_idle_after_ack: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ack |=> !mem_valid);

    a_r10_addr_lamps: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> flip(disp_addr_pnl) == mem_addr);

endmodule

bind console_seq console_seq_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .key_load      (key_load),
    .sw_word_pnl   (sw_word_pnl),
    .mem_valid     (mem_valid),
    .mem_ack       (mem_ack),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .disp_pc_pnl   (disp_pc_pnl),
    .disp_data_pnl (disp_data_pnl),
    .disp_addr_pnl (disp_addr_pnl)
);

// File: tb/test_console_seq.sv
module test_console_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        wr;
        logic [11:0] addr;
        logic [11:0] wdata;
        string       tag;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] sw_word_pnl = '0;
    logic [2:0]  sw_field_pnl = '0;
    logic        key_load = 1'b0, key_dep = 1'b0, key_exam = 1'b0;
    logic        mem_ack = 1'b0;
    logic [11:0] mem_rdata = '0;
    logic        mem_valid, mem_write;
    logic [11:0] mem_addr, mem_wdata, disp_pc_pnl, disp_data_pnl, disp_addr_pnl;
    logic [2:0]  disp_field_pnl;

    logic        r_dep = 1'b0, r_ack = 1'b0;
    logic [11:0] r_sw = '0;
    logic        r_valid, r_write;
    logic [11:0] r_addr, r_wdata, r_pc, r_data, r_alamp;
    logic [2:0]  r_field;

    int check_cnt = 0;
    int bad_cnt = 0;
    int lat = 0;
    bit finished = 0;

    txn_t exp_q[$];
    txn_t obs_q[$];
    logic [11:0] mem_model [logic [11:0]];
    logic [11:0] shadow [logic [11:0]];
    logic [11:0] exp_pc = '0;
    logic [11:0] exp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    console_seq i_console_seq (
        .clk(clk), .rst(rst), .sw_word_pnl(sw_word_pnl), .sw_field_pnl(sw_field_pnl),
        .key_load(key_load), .key_dep(key_dep), .key_exam(key_exam),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .disp_pc_pnl(disp_pc_pnl), .disp_data_pnl(disp_data_pnl),
        .disp_addr_pnl(disp_addr_pnl), .disp_field_pnl(disp_field_pnl)
    );

    console_seq #(.DEP_ON_RELEASE(1'b1)) i_console_seq_rel (
        .clk(clk), .rst(rst), .sw_word_pnl(r_sw), .sw_field_pnl(3'b000),
        .key_load(1'b0), .key_dep(r_dep), .key_exam(1'b0),
        .mem_ack(r_ack), .mem_rdata(12'o0000),
        .mem_valid(r_valid), .mem_write(r_write), .mem_addr(r_addr),
        .mem_wdata(r_wdata), .disp_pc_pnl(r_pc), .disp_data_pnl(r_data),
        .disp_addr_pnl(r_alamp), .disp_field_pnl(r_field)
    );

    function automatic logic [11:0] flip12(input logic [11:0] v);
        logic [11:0] r;
        for (int i = 0; i < 12; i++) r[i] = v[11-i];
        return r;
    endfunction

    function automatic logic [11:0] fill(input logic [11:0] a);
        return a ^ 12'o5252;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [11:0] act,
                         input logic [11:0] exp);
        check_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", check_cnt, bad_cnt);
            $finish;
        end
    endtask

    // memory responder: acknowledges after lat idle cycles, records requests
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_valid) begin
                if (wcnt >= lat) begin
                    obs_q.push_back('{mem_write, mem_addr, mem_wdata, ""});
                    if (mem_write) mem_model[mem_addr] = mem_wdata;
                    else mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : fill(mem_addr);
                    mem_ack = 1'b1;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        txn_t o, e;
        forever begin
            wait (obs_q.size() > 0);
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R6/R7 unexpected request", o.addr, 12'o0000);
            end else begin
                e = exp_q.pop_front();
                check(o.wr == e.wr, {e.tag, " direction"}, 12'(o.wr), 12'(e.wr));
                check(o.addr == e.addr, {e.tag, " address"}, o.addr, e.addr);
                if (e.wr) check(o.wdata == e.wdata, {e.tag, " write data"}, o.wdata, e.wdata);
            end
        end
    end

    // responder for the release-mode instance
    initial begin
        forever begin
            @(negedge clk);
            r_ack = r_valid && !r_ack;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 12'o0000, 12'o0000);
        summary();
    end

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic keys(input bit l, input bit d, input bit e, input int hold);
        @(negedge clk);
        key_load = l; key_dep = d; key_exam = e;
        repeat (hold) @(negedge clk);
        key_load = 0; key_dep = 0; key_exam = 0;
        settle();
    endtask

    task automatic do_load(input logic [11:0] v);
        sw_word_pnl = flip12(v);
        keys(1, 0, 0, 2);
        exp_pc = v;
        check(disp_pc_pnl == flip12(v), "R2 set address", flip12(disp_pc_pnl), v);
    endtask

    task automatic do_dep(input logic [11:0] v, input string tag);
        sw_word_pnl = flip12(v);
        exp_q.push_back('{1'b1, exp_pc, v, tag});
        shadow[exp_pc] = v;
        keys(0, 1, 0, 2);
        exp_pc = exp_pc + 12'd1;
        check(disp_pc_pnl == flip12(exp_pc), {tag, " pc after"}, flip12(disp_pc_pnl), exp_pc);
    endtask

    task automatic do_exam(input string tag);
        exp_q.push_back('{1'b0, exp_pc, 12'o0000, tag});
        exp_data = shadow.exists(exp_pc) ? shadow[exp_pc] : fill(exp_pc);
        keys(0, 0, 1, 2);
        exp_pc = exp_pc + 12'd1;
        check(disp_data_pnl == flip12(exp_data), {tag, " data lamps"}, flip12(disp_data_pnl), exp_data);
        check(disp_pc_pnl == flip12(exp_pc), {tag, " pc after"}, flip12(disp_pc_pnl), exp_pc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1
        check(!mem_valid, "R1 no request after reset", 12'(mem_valid), 12'o0000);
        check(disp_pc_pnl == 12'o0000, "R1 pc lamps", disp_pc_pnl, 12'o0000);
        check(disp_data_pnl == 12'o0000, "R1 data lamps", disp_data_pnl, 12'o0000);
        check(disp_addr_pnl == 12'o0000, "R1 address lamps", disp_addr_pnl, 12'o0000);

        // R12
        sw_field_pnl = 3'b011;
        #1;
        check(disp_field_pnl == 3'b011, "R12 field lamps", 12'(disp_field_pnl), 12'o0003);

        // R2, R9: asymmetric pattern through the reversed inputs
        do_load(12'o0001);
        do_load(12'o0100);

        // R3 with two latencies
        lat = 0;
        do_dep(12'o1111, "R3 deposit lat0");
        lat = 2;
        do_dep(12'o2222, "R3 deposit lat2");

        // R4
        do_load(12'o0100);
        lat = 1;
        do_exam("R4 examine first");
        do_exam("R4 examine second");
        do_exam("R4 examine unwritten");

        // R10: address lamps keep last access
        check(disp_addr_pnl == flip12(12'o0102), "R10 address held", flip12(disp_addr_pnl), 12'o0102);

        // R5: key held for a long time
        do_load(12'o0200);
        sw_word_pnl = flip12(12'o4321);
        exp_q.push_back('{1'b1, 12'o0200, 12'o4321, "R5 held deposit"});
        shadow[12'o0200] = 12'o4321;
        keys(0, 1, 0, 25);
        exp_pc = 12'o0201;
        check(disp_pc_pnl == flip12(exp_pc), "R5 single advance", flip12(disp_pc_pnl), exp_pc);

        // R6 and R10: examine pulsed while a deposit is outstanding
        lat = 4;
        sw_word_pnl = flip12(12'o3333);
        exp_q.push_back('{1'b1, 12'o0201, 12'o3333, "R6 busy deposit"});
        shadow[12'o0201] = 12'o3333;
        @(negedge clk);
        key_dep = 1;
        @(negedge clk);
        @(negedge clk);
        key_exam = 1;
        check(mem_valid && disp_addr_pnl == flip12(12'o0201), "R10 address during access",
              flip12(disp_addr_pnl), 12'o0201);
        @(negedge clk);
        @(negedge clk);
        key_exam = 0;
        key_dep = 0;
        settle();
        exp_pc = 12'o0202;
        check(disp_pc_pnl == flip12(exp_pc), "R6 pc after busy", flip12(disp_pc_pnl), exp_pc);
        check(disp_data_pnl == flip12(exp_data), "R6 examine ignored", flip12(disp_data_pnl), exp_data);

        // R7: set-address beats deposit, deposit beats examine
        lat = 1;
        sw_word_pnl = flip12(12'o0400);
        keys(1, 1, 0, 2);
        exp_pc = 12'o0400;
        check(disp_pc_pnl == flip12(exp_pc), "R7 set address wins", flip12(disp_pc_pnl), exp_pc);
        exp_q.push_back('{1'b1, 12'o0400, 12'o0400, "R7 deposit wins"});
        shadow[12'o0400] = 12'o0400;
        keys(0, 1, 1, 2);
        exp_pc = 12'o0401;
        check(disp_pc_pnl == flip12(exp_pc), "R7 pc after deposit", flip12(disp_pc_pnl), exp_pc);
        check(disp_data_pnl == flip12(exp_data), "R7 examine dropped", flip12(disp_data_pnl), exp_data);

        // R8
        do_load(12'o7777);
        do_dep(12'o0042, "R8 wrap deposit");
        check(disp_pc_pnl == 12'o0000, "R8 wrap to zero", flip12(disp_pc_pnl), 12'o0000);

        // R11: release-mode instance
        r_sw = flip12(12'o1234);
        @(negedge clk);
        r_dep = 1;
        repeat (4) @(negedge clk);
        check(!r_valid, "R11 press alone idle", 12'(r_valid), 12'o0000);
        r_dep = 0;
        @(negedge clk);
        check(r_valid && r_write, "R11 release starts write", 12'(r_valid), 12'o0001);
        check(r_addr == 12'o0000 && r_wdata == 12'o1234, "R11 write fields", r_wdata, 12'o1234);
        settle();
        check(r_pc == flip12(12'o0001), "R11 pc after", flip12(r_pc), 12'o0001);

        settle();
        check(exp_q.size() == 0, "R3/R4 missing requests", 12'(exp_q.size()), 12'o0000);
        summary();
    end

endmodule